// File: doc/BRIEF.md
# UART Multi-Mode Oversampling Baud Generator

This block produces the bit-timing strobes for a 16550-style serial port that also offers faster modes. A 16-bit prescaler divisor, written one byte at a time through a latch window, divides the system clock into sample ticks. A two-bit oversampling mode then decides how many sample ticks make up one serial bit: a fixed sixteen, a fixed four, or a count set by software. In the programmable mode, software also chooses the tick at which the receiver samples.

Three strobes come out of the block. The sample tick is for receive oversampling. The bit strobe marks bit boundaries for the transmitter. The mid-bit strobe tells the receiver when to sample. A start-edge input from the receiver realigns the per-bit count to an incoming frame. Any write that changes the timing restarts both counters, so the first bit after a change always has full length.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset, the divisor is 0, the line control is 0, the interrupt-enable byte is 0, the mode is 0, the sample count is 0 and the sample point is 0xFF. A divisor of 0 behaves as 1, so sample_tick is high on every cycle until the first write.
- R2: Write addresses are 0 (data or divisor low), 1 (interrupt enable or divisor high), 3 (line control), 9 (mode, bits 1:0), 10 (sample count) and 11 (sample point). Bit 7 of line control is the latch-access bit.
- R3: While the latch-access bit is set, writes to addresses 0 and 1 load divisor bits 7:0 and 15:8. While it is clear, a write to 0 raises thr_load in the same cycle and leaves the divisor unchanged, and a write to 1 loads ier_q and leaves the divisor unchanged.
- R4: sample_tick is a one-cycle pulse repeating every max(D,1) clock cycles, where D is the divisor.
- R5: Mode 0 gives 16 ticks per bit with the mid-bit strobe at tick position 8. Mode 1 is reserved and behaves like mode 0.
- R6: Mode 2 gives 4 ticks per bit with the mid-bit strobe at tick position 2.
- R7: Mode 3 gives (sample count + 1) ticks per bit with the mid-bit strobe at position (sample point). A sample point above the sample count yields no mid-bit strobe.
- R8: A write to address 0 or 1 with the latch-access bit set, or to address 9 or 10, makes the next cycle a restart cycle. A restart cycle has no tick. The first tick comes max(D,1) cycles after it, and the tick position starts at 0.
- R9: A cycle with rx_start high resets the tick position to 0. A tick in that cycle still appears on sample_tick, but it produces no bit strobe or mid-bit strobe, and the following tick is at position 0.
- R10: char_len always shows line-control bits 1:0 (3 means an 8-bit character).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rx_start | input | 1 | Receiver start-edge resync pulse |
| sample_tick | output | 1 | Oversampling tick |
| bit_strobe | output | 1 | Bit boundary strobe for the transmitter |
| rx_strobe | output | 1 | Mid-bit sample strobe for the receiver |
| thr_load | output | 1 | Data register write passed to the transmitter |
| ier_q | output | 8 | Interrupt-enable byte |
| char_len | output | 2 | Character length field |
| div_q | output | 16 | Current prescaler divisor |

## Verification
A receiver start edge and a sample tick can land in the same cycle, and that tick may be the one that would end a bit or trigger a mid-bit sample. The bench provokes this by pulsing rx_start on tick cycles with divisor 1, including the cycle where the mid-bit strobe would otherwise fire. It also pulses rx_start on a cycle between ticks with a larger divisor. Each result is judged cycle by cycle against an arithmetic model. In that model, the coinciding tick is emitted but carries no strobes, and tick counting resumes at position 0.

// File: rtl/ubg_pkg.sv
package ubg_pkg;

  localparam int ADDR_W = 4;
  localparam int POS_W  = 8;

  localparam logic [ADDR_W-1:0] A_DATA = 4'd0;
  localparam logic [ADDR_W-1:0] A_IEN  = 4'd1;
  localparam logic [ADDR_W-1:0] A_LINE = 4'd3;
  localparam logic [ADDR_W-1:0] A_MODE = 4'd9;
  localparam logic [ADDR_W-1:0] A_SCNT = 4'd10;
  localparam logic [ADDR_W-1:0] A_SPT  = 4'd11;

  localparam int LATCH_BIT = 7;

  typedef enum logic [1:0] {
    OVS_16   = 2'd0,
    OVS_RSVD = 2'd1,
    OVS_4    = 2'd2,
    OVS_PROG = 2'd3
  } ovs_mode_e;

  // index of the last tick in a bit
  function automatic logic [POS_W-1:0] last_pos(ovs_mode_e m, logic [POS_W-1:0] scnt);
    case (m)
      OVS_4:    return POS_W'(3);
      OVS_PROG: return scnt;
      default:  return POS_W'(15);
    endcase
  endfunction

  // tick index of the receive sample
  function automatic logic [POS_W-1:0] mid_pos(ovs_mode_e m, logic [POS_W-1:0] spt);
    case (m)
      OVS_4:    return POS_W'(2);
      OVS_PROG: return spt;
      default:  return POS_W'(8);
    endcase
  endfunction

  function automatic logic [15:0] eff_div(logic [15:0] d);
    return (d == 16'd0) ? 16'd1 : d;
  endfunction

endpackage

// File: rtl/ubg_regs.sv
module ubg_regs
  import ubg_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [DIV_W-1:0]  divisor,
  output logic [7:0]        lcr,
  output logic [7:0]        ier,
  output ovs_mode_e         mode,
  output logic [POS_W-1:0]  scnt,
  output logic [POS_W-1:0]  spt,
  output logic              thr_load,
  output logic              restart
);

  localparam int HI_W = DIV_W - 8;

  logic latch_open;
  logic wr_dll, wr_dlm, wr_ier, wr_timing;

  assign latch_open = lcr[LATCH_BIT];
  assign wr_dll     = wr_en && (wr_addr == A_DATA) && latch_open;
  assign wr_dlm     = wr_en && (wr_addr == A_IEN)  && latch_open;
  assign wr_ier     = wr_en && (wr_addr == A_IEN)  && !latch_open;
  assign thr_load   = wr_en && (wr_addr == A_DATA) && !latch_open;
  assign wr_timing  = wr_dll || wr_dlm ||
                      (wr_en && (wr_addr == A_MODE)) ||
                      (wr_en && (wr_addr == A_SCNT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divisor <= '0;
      lcr     <= 8'h00;
      ier     <= 8'h00;
      mode    <= OVS_16;
      scnt    <= '0;
      spt     <= '1;
      restart <= 1'b0;
    end else begin
      restart <= wr_timing;
      if (wr_dll) divisor[7:0] <= wr_data;
      if (wr_dlm) divisor[DIV_W-1:8] <= wr_data[HI_W-1:0];
      if (wr_ier) ier <= wr_data;
      if (wr_en && wr_addr == A_LINE) lcr  <= wr_data;
      if (wr_en && wr_addr == A_MODE) mode <= ovs_mode_e'(wr_data[1:0]);
      if (wr_en && wr_addr == A_SCNT) scnt <= wr_data;
      if (wr_en && wr_addr == A_SPT)  spt  <= wr_data;
    end
  end

  assert_data_keeps_div_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_DATA && !latch_open) |=> $stable(divisor));

  assert_ier_keeps_div_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_IEN && !latch_open) |=> $stable(divisor));

  assert_mode_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MODE) |=> restart);

endmodule

// File: rtl/ubg_prescaler.sv
module ubg_prescaler
  import ubg_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             restart,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_eff;
  logic             at_zero;

  assign div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
  assign at_zero = (cnt == '0);
  assign tick    = at_zero && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart || at_zero) cnt <= div_eff - DIV_W'(1);
    else                     cnt <= cnt - DIV_W'(1);
  end

  assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_eff != DIV_W'(1)) |=> !tick);

  assert_restart_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !tick);

endmodule

// File: rtl/ubg_bit_counter.sv
module ubg_bit_counter
  import ubg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic             rx_start,
  input  logic [POS_W-1:0] last,
  input  logic [POS_W-1:0] mid,
  output logic             bit_strobe,
  output logic             rx_strobe
);

  logic [POS_W-1:0] pos;
  logic             live;
  logic             wrap;

  assign live       = tick && !rx_start;
  assign wrap       = (pos == last);
  assign bit_strobe = live && wrap;
  assign rx_strobe  = live && (pos == mid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pos <= '0;
    else if (restart || rx_start) pos <= '0;
    else if (tick)                pos <= wrap ? '0 : pos + POS_W'(1);
  end

  assert_bit_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> tick);

  assert_rx_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |-> tick);

  assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |=> (pos == '0));

  assert_resync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_start || restart) |=> (pos == '0));

  assert_resync_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start |-> !(bit_strobe || rx_strobe));

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import ubg_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rx_start,
  output logic              sample_tick,
  output logic              bit_strobe,
  output logic              rx_strobe,
  output logic              thr_load,
  output logic [7:0]        ier_q,
  output logic [1:0]        char_len,
  output logic [DIV_W-1:0]  div_q
);

  logic [7:0]       lcr;
  ovs_mode_e        mode;
  logic [POS_W-1:0] scnt, spt;
  logic             restart;
  logic [POS_W-1:0] last, mid;

  ubg_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .divisor(div_q), .lcr(lcr), .ier(ier_q),
    .mode(mode), .scnt(scnt), .spt(spt), .thr_load(thr_load),
    .restart(restart)
  );

  assign last     = last_pos(mode, scnt);
  assign mid      = mid_pos(mode, spt);
  assign char_len = lcr[1:0];

  ubg_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .divisor(div_q), .restart(restart),
    .tick(sample_tick)
  );

  ubg_bit_counter u_bits (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .restart(restart),
    .rx_start(rx_start), .last(last), .mid(mid),
    .bit_strobe(bit_strobe), .rx_strobe(rx_strobe)
  );

  assert_len_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_LINE) |=> (char_len == $past(wr_data[1:0])));

endmodule

// File: tb/sim_uart_baud_gen.sv
`timescale 1ns/1ps
module sim_uart_baud_gen;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic rx_start = 1'b0;
  logic sample_tick, bit_strobe, rx_strobe, thr_load;
  logic [7:0] ier_q;
  logic [1:0] char_len;
  logic [15:0] div_q;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  uart_baud_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rx_start(rx_start), .sample_tick(sample_tick),
    .bit_strobe(bit_strobe), .rx_strobe(rx_strobe), .thr_load(thr_load),
    .ier_q(ier_q), .char_len(char_len), .div_q(div_q)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one register write; returns at the negedge of the cycle after the write edge
  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // cycle-exact comparison starting in the restart cycle (c = 0)
  task automatic run(string req, int d, int r, int sp, int len, int rs1, int rs2);
    int de = (d == 0) ? 1 : d;
    int n = 0;
    int bad = 0;
    for (int c = 0; c < len; c++) begin
      bit te, be, xe;
      rx_start = (c == rs1 || c == rs2);
      #1;
      te = (c > 0) && (c % de == 0);
      be = 0; xe = 0;
      if (te) begin
        if (rx_start) n = 0;
        else begin
          be = ((n % r) == r - 1);
          xe = ((n % r) == sp);
          n++;
        end
      end else if (rx_start) n = 0;
      if (sample_tick !== te || bit_strobe !== be || rx_strobe !== xe) begin
        if (bad == 0)
          $display("FAIL %s cycle %0d actual=%b%b%b expected=%b%b%b", req, c,
                   sample_tick, bit_strobe, rx_strobe, te, be, xe);
        bad++;
      end
      @(negedge clk);
      rx_start = 1'b0;
    end
    tests++;
    if (bad != 0) fails++;
  endtask

  task automatic cfg(int d, int mode, int scnt, int spt, int last_reg);
    wr(3, 8'h83);
    wr(0, d & 8'hFF);
    wr(1, (d >> 8) & 8'hFF);
    wr(3, 8'h03);
    wr(11, spt);
    if (last_reg == 10) begin
      wr(9, mode); wr(10, scnt);
    end else begin
      wr(10, scnt); wr(9, mode);
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int divs[3] = '{0, 1, 3};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 div", div_q, 0);
    check("R1 ier", ier_q, 0);
    check("R1 len", char_len, 0);
    check("R1 tick", sample_tick, 1);
    @(negedge clk); #1;
    check("R1 tick again", sample_tick, 1);

    // R2 R3 latch window
    @(negedge clk);
    wr_en = 1; wr_addr = 4'd0; wr_data = 8'h55; #1;
    check("R3 thr_load", thr_load, 1);
    @(negedge clk); wr_en = 0; #1;
    check("R3 data keeps div", div_q, 0);
    wr(1, 8'hA5); #1;
    check("R3 ier write", ier_q, 8'hA5);
    check("R3 ier keeps div", div_q, 0);
    wr(3, 8'h80);
    wr(0, 8'h34);
    wr(1, 8'h12); #1;
    check("R3 div load", div_q, 16'h1234);
    check("R3 ier untouched", ier_q, 8'hA5);
    @(negedge clk);
    wr_en = 1; wr_addr = 4'd0; wr_data = 8'h77; #1;
    check("R3 no thr_load in window", thr_load, 0);
    @(negedge clk); wr_en = 0;
    wr(3, 8'h03); #1;
    check("R10 char_len", char_len, 3);

    // R4 R5 R6 R8 sweep over fixed modes
    foreach (divs[i]) begin
      int d = divs[i];
      int de = (d == 0) ? 1 : d;
      cfg(d, 0, 0, 8'hFF, 9);
      run($sformatf("R5 mode0 D=%0d", d), d, 16, 8, de * 32 + 3, -1, -1);
      cfg(d, 1, 0, 8'hFF, 9);
      run($sformatf("R5 mode1 D=%0d", d), d, 16, 8, de * 32 + 3, -1, -1);
      cfg(d, 2, 0, 8'hFF, 9);
      run($sformatf("R6 mode2 D=%0d", d), d, 4, 2, de * 8 + 3, -1, -1);
      cfg(d, 2, 0, 8'hFF, 10);
      run($sformatf("R8 scnt restart D=%0d", d), d, 4, 2, de * 8 + 3, -1, -1);
    end
    // R4 prescaler period and R8 divisor-write restart
    cfg(5, 0, 0, 8'hFF, 9);
    wr(3, 8'h80); wr(1, 0); wr(0, 5);
    run("R4 R8 D=5 restart by divisor", 5, 16, 8, 5 * 20, -1, -1);
    wr(3, 8'h03);

    // R7 programmable sweep
    for (int s = 0; s < 7; s++) begin
      for (int k = 0; k < 3; k++) begin
        int p = (k == 0) ? ((s > 1) ? (s - 1) / 2 : 0) : ((k == 1) ? s : s + 3);
        cfg(2, 3, s, p, 9);
        run($sformatf("R7 prog s=%0d p=%0d", s, p), 2, s + 1, p, 2 * (s + 1) * 3 + 3, -1, -1);
      end
    end

    // R9 resync: coinciding with tick and with mid-bit strobe, and between ticks
    cfg(1, 0, 0, 8'hFF, 9);
    run("R9 resync at mid-bit tick", 1, 16, 8, 60, 9, -1);
    cfg(1, 2, 0, 8'hFF, 9);
    run("R9 resync at bit end", 1, 4, 2, 30, 4, 11);
    cfg(3, 0, 0, 8'hFF, 9);
    run("R9 resync between ticks", 3, 16, 8, 120, 20, -1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule